// File: doc/BRIEF.md
# UART Transmit Collision Guard

This block watches a UART whose transmit and receive lines share one wire, either a half-duplex bus or a loopback. At every mid-bit sample strobe during a transmission, it compares the level the transmitter is driving with the level the receiver reads back. If the two levels differ, another driver has taken the line, and the block shuts the transmitter down in hardware. It pulses an abort for the frame in flight and a flush for the transmit buffer. Next it waits through a fixed synchronization delay, with a control-busy indication raised. At the end of that delay it pulses a request to clear the transmitter enable and releases the TxD pad to high impedance.

The block raises a sticky collision status bit and a sticky error interrupt flag. Software clears each one by writing a one to it. After a collision, the guard ignores all further mismatches until software re-enables the transmitter, which it sees as a rising edge on the transmit-enable control.

All pins carry plain control or status signals. No data stream passes through the block, so it has no valid/ready handshake and no back-pressure rules.

Top module: `uart_coll_guard`

## Requirements
- R1: Checking runs only while coll_en_i, tx_en_i and rx_en_i are all 1. If any of them is 0, a mismatch causes no abort.
- R2: A check is made only in a cycle where sample_stb_i is 1 and tx_active_i is 1. It fires when rx_bit_i differs from tx_bit_i, for either polarity and for any bit of the frame, including the start bit. Without a strobe, nothing is checked.
- R3: While tx_active_i is 0, received levels never cause a collision.
- R4: A strobe where rx_bit_i equals tx_bit_i has no effect on any output.
- R5: A detected collision produces a one-cycle pulse on both abort_o and flush_o. The pulse appears in the cycle right after the clock edge that sampled the strobe.
- R6: ctrl_busy_o rises together with abort_o and stays high for exactly SYNC_CYCLES cycles (default 2). In the cycle after it falls, tx_en_clr_o pulses for one cycle and txd_oe_o drops to 0.
- R7: coll_sts_o and err_irq_o are set together with abort_o. Each stays set until it is cleared.
- R8: flags_clr_i is write-one-to-clear. Bit 0 clears coll_sts_o and bit 1 clears err_irq_o, each at the next edge. A new collision in the same cycle takes priority over the clear.
- R9: From detection onward, mismatches are ignored. This holds until tx_en_i has been seen at 0 and then at 1 again.
- R10: txd_oe_o equals tx_en_i while no shutdown has locked the transmitter. After reset, all pulse and status outputs are 0 and the transmitter is not locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| coll_en_i | input | 1 | Collision detection enable |
| tx_en_i | input | 1 | Transmitter enable from the control register |
| rx_en_i | input | 1 | Receiver enable |
| tx_active_i | input | 1 | A frame is being shifted out |
| tx_bit_i | input | 1 | Level the transmitter is driving |
| rx_bit_i | input | 1 | Synchronized receive level |
| sample_stb_i | input | 1 | Mid-bit sample strobe |
| flags_clr_i | input | 2 | Write-one-to-clear: bit 0 collision status, bit 1 error flag |
| abort_o | output | 1 | Abort pulse for the current transfer |
| flush_o | output | 1 | Transmit buffer flush pulse |
| tx_en_clr_o | output | 1 | Pulse that clears the transmitter enable |
| txd_oe_o | output | 1 | TxD pad output enable |
| coll_sts_o | output | 1 | Sticky collision status |
| err_irq_o | output | 1 | Sticky error interrupt flag |
| ctrl_busy_o | output | 1 | Control synchronization busy |

## Verification
The embedded assertions check the fixed relations on every cycle. Busy rises together with abort and flush. The enable-clear pulse arrives only once busy has ended and the pad is released. The flags are set in the abort cycle, and an abort never follows while busy is high. Gating by the enables and by transmit activity is also checked on every cycle. Only the bench scenarios can show three further behaviours: the exact length of the busy window, the lock surviving until software re-enables the transmitter, and a simultaneous set winning over a clear.

// File: rtl/uart_coll_pkg.sv
package uart_coll_pkg;
  localparam int unsigned FLAG_COUNT = 2;
  localparam int unsigned FLAG_COLL  = 0;
  localparam int unsigned FLAG_ERR   = 1;
  typedef logic [FLAG_COUNT-1:0] flag_vec_t;
endpackage

// File: rtl/coll_compare.sv
module coll_compare (
  input  logic coll_en_i,
  input  logic tx_en_i,
  input  logic rx_en_i,
  input  logic tx_active_i,
  input  logic sample_stb_i,
  input  logic armed_i,
  input  logic tx_bit_i,
  input  logic rx_bit_i,
  output logic hit_o
);
  logic gate_open;
  always_comb begin
    gate_open = coll_en_i & tx_en_i & rx_en_i & tx_active_i & sample_stb_i & armed_i;
    hit_o     = gate_open & (tx_bit_i ^ rx_bit_i);
  end
endmodule

// File: rtl/coll_shutdown.sv
module coll_shutdown #(
  parameter int unsigned SYNC_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hit_i,
  input  logic tx_en_i,
  output logic armed_o,
  output logic abort_o,
  output logic busy_o,
  output logic clr_o,
  output logic locked_o
);
  localparam int unsigned CNT_W = $clog2(SYNC_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             tx_en_q;
  logic             re_enable;

  assign re_enable = tx_en_i & ~tx_en_q;
  assign busy_o    = (cnt_q != '0);
  assign armed_o   = ~locked_o & ~busy_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      tx_en_q  <= 1'b0;
      abort_o  <= 1'b0;
      clr_o    <= 1'b0;
      locked_o <= 1'b0;
    end else begin
      tx_en_q <= tx_en_i;
      abort_o <= hit_i;
      clr_o   <= 1'b0;
      if (hit_i) begin
        cnt_q <= CNT_W'(SYNC_CYCLES);
      end else if (busy_o) begin
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          clr_o    <= 1'b1;
          locked_o <= 1'b1;
        end
      end else if (re_enable) begin
        locked_o <= 1'b0;
      end
    end
  end

  AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o || locked_o) |=> !abort_o || $past(busy_o)) // R9
    else $error("retrigger while shut down");
  AST_CLR_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    clr_o |-> !busy_o && locked_o && $past(busy_o)) // R6
    else $error("enable clear out of sequence");
endmodule

// File: rtl/coll_flags.sv
module coll_flags
  import uart_coll_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      set_i,
  input  flag_vec_t clr_i,
  output flag_vec_t flags_o
);
  for (genvar g = 0; g < FLAG_COUNT; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         flags_o[g] <= 1'b0;
      else if (set_i)     flags_o[g] <= 1'b1;
      else if (clr_i[g])  flags_o[g] <= 1'b0;
    end
  end

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_o[FLAG_COLL] && !clr_i[FLAG_COLL]) |=> flags_o[FLAG_COLL]) // R7
    else $error("collision status lost");
endmodule

// File: rtl/uart_coll_guard.sv
module uart_coll_guard
  import uart_coll_pkg::*;
#(
  parameter int unsigned SYNC_CYCLES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       coll_en_i,
  input  logic       tx_en_i,
  input  logic       rx_en_i,
  input  logic       tx_active_i,
  input  logic       tx_bit_i,
  input  logic       rx_bit_i,
  input  logic       sample_stb_i,
  input  logic [1:0] flags_clr_i,
  output logic       abort_o,
  output logic       flush_o,
  output logic       tx_en_clr_o,
  output logic       txd_oe_o,
  output logic       coll_sts_o,
  output logic       err_irq_o,
  output logic       ctrl_busy_o
);
  logic      hit, armed, locked, abort_q;
  flag_vec_t flags;

  coll_compare u_cmp (
    .coll_en_i   (coll_en_i),
    .tx_en_i     (tx_en_i),
    .rx_en_i     (rx_en_i),
    .tx_active_i (tx_active_i),
    .sample_stb_i(sample_stb_i),
    .armed_i     (armed),
    .tx_bit_i    (tx_bit_i),
    .rx_bit_i    (rx_bit_i),
    .hit_o       (hit)
  );

  coll_shutdown #(.SYNC_CYCLES(SYNC_CYCLES)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit_i   (hit),
    .tx_en_i (tx_en_i),
    .armed_o (armed),
    .abort_o (abort_q),
    .busy_o  (ctrl_busy_o),
    .clr_o   (tx_en_clr_o),
    .locked_o(locked)
  );

  coll_flags u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (hit),
    .clr_i  (flags_clr_i),
    .flags_o(flags)
  );

  assign abort_o    = abort_q;
  assign flush_o    = abort_q;
  assign txd_oe_o   = tx_en_i & ~locked;
  assign coll_sts_o = flags[FLAG_COLL];
  assign err_irq_o  = flags[FLAG_ERR];

  AST_BUSY_WITH_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_busy_o) |-> abort_o && flush_o) // R5
    else $error("busy rose without abort");
  AST_FLAGS_ON_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> coll_sts_o && err_irq_o) // R7
    else $error("flags not set on abort");
  AST_PAD_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en_clr_o |-> !txd_oe_o) // R6
    else $error("pad still driven after clear");
  AST_GATE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (!coll_en_i || !rx_en_i) |=> !abort_o) // R1
    else $error("abort while checking disabled");
  AST_IDLE_NO_COLL: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_active_i |=> !abort_o) // R3
    else $error("abort while transmitter idle");
endmodule

// File: tb/uart_coll_guard_tb_top.sv
module uart_coll_guard_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic coll_en, tx_en, rx_en, tx_act, tx_bit, rx_bit, stb;
  logic [1:0] fclr;
  logic abort, flush, en_clr, oe, csts, eirq, busy;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  uart_coll_guard #(.SYNC_CYCLES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .coll_en_i(coll_en), .tx_en_i(tx_en),
    .rx_en_i(rx_en), .tx_active_i(tx_act), .tx_bit_i(tx_bit), .rx_bit_i(rx_bit),
    .sample_stb_i(stb), .flags_clr_i(fclr), .abort_o(abort), .flush_o(flush),
    .tx_en_clr_o(en_clr), .txd_oe_o(oe), .coll_sts_o(csts), .err_irq_o(eirq),
    .ctrl_busy_o(busy)
  );

  // {coll_en, tx_en, rx_en, tx_active, tx_bit, rx_bit, expected abort}
  localparam logic [6:0] VEC [8] = '{
    7'b1111_01_1,  // R2 start bit forced high
    7'b1111_10_1,  // R2 opposite polarity
    7'b1111_00_0,  // R4 match low
    7'b1111_11_0,  // R4 match high
    7'b0111_01_0,  // R1 detection off
    7'b1101_01_0,  // R1 receiver off
    7'b1110_10_0,  // R3 idle transmitter
    7'b1011_01_0   // R1 transmitter off
  };

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic recover();
    stb = 1'b0; tx_en = 1'b0;
    repeat (4) @(negedge clk);
    tx_en = 1'b1;
    @(negedge clk);
    fclr = 2'b11;
    @(negedge clk);
    fclr = 2'b00;
  endtask

  task automatic strike(input logic t, input logic r);
    tx_act = 1'b1; tx_bit = t; rx_bit = r; stb = 1'b1;
    @(negedge clk);
    stb = 1'b0;
  endtask

  initial begin
    coll_en = 1'b1; tx_en = 1'b0; rx_en = 1'b1; tx_act = 1'b0;
    tx_bit = 1'b1; rx_bit = 1'b1; stb = 1'b0; fclr = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 reset abort", abort, 1'b0);
    check("R10 reset busy", busy, 1'b0);
    check("R10 reset status", csts, 1'b0);
    check("R10 reset error", eirq, 1'b0);
    check("R10 oe follows disabled enable", oe, 1'b0);
    tx_en = 1'b1; #1;
    check("R10 oe follows enable", oe, 1'b1);
    @(negedge clk);

    foreach (VEC[i]) begin
      {coll_en, tx_en, rx_en} = VEC[i][6:4];
      @(negedge clk);
      tx_act = VEC[i][3]; tx_bit = VEC[i][2]; rx_bit = VEC[i][1]; stb = 1'b1;
      @(negedge clk);
      stb = 1'b0;
      check($sformatf("R1/R2/R3/R4 vector %0d abort", i), abort, VEC[i][0]);
      check($sformatf("R5 vector %0d flush", i), flush, VEC[i][0]);
      coll_en = 1'b1; rx_en = 1'b1;
      recover();
    end

    // R5 R6 R7 shutdown sequence
    strike(1'b0, 1'b1);
    check("R5 abort pulse", abort, 1'b1);
    check("R5 flush pulse", flush, 1'b1);
    check("R6 busy first cycle", busy, 1'b1);
    check("R7 status set", csts, 1'b1);
    check("R7 error set", eirq, 1'b1);
    check("R6 oe still on", oe, 1'b1);
    @(negedge clk);
    check("R5 abort single cycle", abort, 1'b0);
    check("R6 busy second cycle", busy, 1'b1);
    check("R6 no early clear", en_clr, 1'b0);
    @(negedge clk);
    check("R6 busy ends", busy, 1'b0);
    check("R6 enable clear pulse", en_clr, 1'b1);
    check("R6 pad released", oe, 1'b0);
    @(negedge clk);
    check("R6 clear single cycle", en_clr, 1'b0);

    // R9 locked: mismatch ignored while tx_en stays high
    strike(1'b1, 1'b0);
    check("R9 ignored while locked", abort, 1'b0);
    check("R7 status sticky", csts, 1'b1);

    // R8 write-one-to-clear per bit
    fclr = 2'b01; @(negedge clk); fclr = 2'b00;
    check("R8 status cleared", csts, 1'b0);
    check("R8 error kept", eirq, 1'b1);
    fclr = 2'b10; @(negedge clk); fclr = 2'b00;
    check("R8 error cleared", eirq, 1'b0);

    // R9 re-enable arms again; R8 set beats clear
    tx_en = 1'b0; @(negedge clk); tx_en = 1'b1; @(negedge clk);
    check("R10 oe back after re-enable", oe, 1'b1);
    fclr = 2'b11;
    strike(1'b0, 1'b1);
    fclr = 2'b00;
    check("R9 re-armed after re-enable", abort, 1'b1);
    check("R8 set wins status", csts, 1'b1);
    check("R8 set wins error", eirq, 1'b1);
    recover();

    // R2 no strobe, no check
    tx_act = 1'b1; tx_bit = 1'b0; rx_bit = 1'b1; stb = 1'b0;
    @(negedge clk);
    check("R2 no strobe no abort", abort, 1'b0);
    check("R2 no strobe no status", csts, 1'b0);
    tx_act = 1'b0;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule